// File: doc/BRIEF.md
# PHY-Side Link Interface Sequencer

This block runs the PHY end of a clocked interface to a link-layer controller. The interface has a 2-bit control bus and an 8-bit data bus. Each bus is split into an output value, a shared output enable and an input value, so that the pad ring can make them bidirectional. The PHY owns both buses by default. It uses them to deliver status bits to the link, to forward a received packet, and to hand the buses over when the link has won the right to transmit.

Three kinds of request arrive from the rest of the PHY: a status delivery carrying a status word, a receive stream with its speed code, and a won-arbitration pulse carrying a grant type and the speed code of the link's pending request. After a grant the block releases its drivers. It then watches the link's control and data buses, passes the link's bytes to the transmit path, and takes the buses back when the link signals the end. A request whose speed code is out of range still gets its grant, but the link's bytes are suppressed so that a null packet results.

Top module: `phy_link_seq`

## Requirements
- R1: After reset, the bus enable is 1, the control and data outputs are 0, and tx_vld, tx_null and tx_end are 0.
- R2: A pending status word is sent only from idle. It is sent as STAT_W/2 cycles with control 01, carrying two bits per cycle on data[1:0], least significant pair first, with data[7:2] at 0. Control 00 follows.
- R3: A receive is sent as one cycle of control 10 with data FFh, then control 10 with data = {5'b0, speed}, then the packet bytes in order, then control 00. A start from idle shows FFh on the edge after rx_act is first sampled high.
- R4: A receive that starts while a status word is pending or being sent takes the bus at once. The whole status word is sent again from its first pair after the receive has ended and the bus has shown one idle cycle.
- R5: A grant is sent as control 11 with data = {5'b0, grant type} for one cycle, then control 00 for one cycle. The enable drops on the following cycle.
- R6: While the buses are released, each cycle in which the link drives control 01 gives tx_vld=1 and tx_byte equal to the link's data, one cycle later.
- R7: Link control 11 (hold) produces no tx_vld and keeps the buses released.
- R8: Before its first hold or transmit cycle, the link may drive control 00 for one cycle. A second such cycle ends the ownership.
- R9: Link control 00 after a hold or transmit ends the ownership. tx_end pulses for one cycle, and the enable returns with control and data at 0 in that same cycle.
- R10: A request speed code above MAX_SPD (default 3) sets tx_null for the whole release period and suppresses tx_vld. tx_null clears when the enable returns.
- R11: When a grant and a status word are both pending in idle, the grant goes first. The status word is sent right after the ownership ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_req | input | 1 | Pulse: latch a status word for delivery |
| stat_bits | input | STAT_W | Status word |
| rx_act | input | 1 | High while a received packet is streaming |
| rx_spd | input | 3 | Speed code of the received packet, valid when rx_act rises |
| rx_byte | input | 8 | Received packet byte, one per cycle after the start |
| arb_won | input | 1 | Pulse: arbitration won for the link |
| gnt_type | input | 3 | Grant type to show during the grant cycle |
| req_spd | input | 3 | Speed code of the link's request |
| ctl_i | input | 2 | Control bus as driven by the link |
| d_i | input | 8 | Data bus as driven by the link |
| ctl_o | output | 2 | Control bus value driven by the PHY |
| d_o | output | 8 | Data bus value driven by the PHY |
| bus_oe | output | 1 | Output enable for both buses |
| tx_vld | output | 1 | A link byte is valid on tx_byte |
| tx_byte | output | 8 | Byte forwarded from the link |
| tx_null | output | 1 | Current ownership yields a null packet |
| tx_end | output | 1 | Pulse: link ownership ended |

## Verification
The hardest case to reach is a receive landing in the middle of a status transfer. The status must already have left idle and shown its first pair when rx_act is sampled. The stimulus raises stat_req, waits exactly two cycles so that the first pair is on the bus, and then starts a one-byte receive. The scoreboard then expects the preempted status word to come back complete, from its first pair, after one idle cycle. Another scenario combines a pending grant and a pending status word, and the link then idles twice, so that both the priority order and the rule that ends ownership at the second idle cycle are observed in one run.

// File: rtl/phy_link_seq.sv
module phy_link_seq #(
  parameter int STAT_W  = 8,
  parameter int MAX_SPD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_req,
  input  logic [STAT_W-1:0] stat_bits,
  input  logic              rx_act,
  input  logic [2:0]        rx_spd,
  input  logic [7:0]        rx_byte,
  input  logic              arb_won,
  input  logic [2:0]        gnt_type,
  input  logic [2:0]        req_spd,
  input  logic [1:0]        ctl_i,
  input  logic [7:0]        d_i,
  output logic [1:0]        ctl_o,
  output logic [7:0]        d_o,
  output logic              bus_oe,
  output logic              tx_vld,
  output logic [7:0]        tx_byte,
  output logic              tx_null,
  output logic              tx_end
);
  localparam int NCH = STAT_W / 2;
  localparam int CW  = $clog2(NCH + 1);
  localparam logic [CW-1:0] LAST_CH = CW'(NCH);
  localparam logic [2:0] SPD_LIM = 3'(MAX_SPD);

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_RXON, S_RXD, S_GNT, S_GIDL, S_LNK} st_t;
  st_t st;

  logic              spend, gpend, gbad, idle_used, started;
  logic [STAT_W-1:0] sbits, shreg;
  logic [CW-1:0]     cnt;
  logic [2:0]        gtype, spd_q;
  logic [7:0]        rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ctl_o <= 2'b00; d_o <= 8'h00; bus_oe <= 1'b1;
      tx_vld <= 1'b0; tx_byte <= 8'h00; tx_null <= 1'b0; tx_end <= 1'b0;
      spend <= 1'b0; gpend <= 1'b0; gbad <= 1'b0;
      idle_used <= 1'b0; started <= 1'b0;
      sbits <= '0; shreg <= '0; cnt <= '0;
      gtype <= 3'd0; spd_q <= 3'd0; rx_q <= 8'h00;
    end else begin
      tx_vld <= 1'b0;
      tx_end <= 1'b0;
      if (stat_req) begin
        spend <= 1'b1;
        sbits <= stat_bits;
      end
      if (arb_won) begin
        gpend <= 1'b1;
        gtype <= gnt_type;
        gbad  <= req_spd > SPD_LIM;
      end
      case (st)
        S_IDLE: begin
          ctl_o <= 2'b00;
          d_o   <= 8'h00;
          if (ctl_o == 2'b00) begin
            if (rx_act) begin
              ctl_o <= 2'b10; d_o <= 8'hFF; spd_q <= rx_spd; st <= S_RXON;
            end else if (gpend) begin
              ctl_o <= 2'b11; d_o <= {5'b0, gtype}; gpend <= 1'b0; st <= S_GNT;
            end else if (spend) begin
              ctl_o <= 2'b01; d_o <= {6'b0, sbits[1:0]};
              shreg <= sbits >> 2; cnt <= CW'(1); st <= S_STAT;
            end
          end
        end
        S_STAT: begin
          if (rx_act) begin
            ctl_o <= 2'b10; d_o <= 8'hFF; spd_q <= rx_spd; st <= S_RXON;
          end else if (cnt == LAST_CH) begin
            ctl_o <= 2'b00; d_o <= 8'h00; st <= S_IDLE;
            if (!stat_req) spend <= 1'b0;
          end else begin
            d_o   <= {6'b0, shreg[1:0]};
            shreg <= shreg >> 2;
            cnt   <= cnt + CW'(1);
          end
        end
        S_RXON: begin
          d_o  <= {5'b0, spd_q};
          rx_q <= rx_byte;
          st   <= rx_act ? S_RXD : S_IDLE;
        end
        S_RXD: begin
          d_o  <= rx_q;
          rx_q <= rx_byte;
          if (!rx_act) st <= S_IDLE;
        end
        S_GNT: begin
          ctl_o <= 2'b00; d_o <= 8'h00; st <= S_GIDL;
        end
        S_GIDL: begin
          bus_oe <= 1'b0; idle_used <= 1'b0; started <= 1'b0;
          tx_null <= gbad; st <= S_LNK;
        end
        S_LNK: begin
          case (ctl_i)
            2'b01: begin
              started <= 1'b1;
              if (!tx_null) begin
                tx_vld  <= 1'b1;
                tx_byte <= d_i;
              end
            end
            2'b11: started <= 1'b1;
            default: begin
              if (!started && !idle_used) idle_used <= 1'b1;
              else begin
                tx_end <= 1'b1; bus_oe <= 1'b1; ctl_o <= 2'b00; d_o <= 8'h00;
                tx_null <= 1'b0; st <= S_IDLE;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && ctl_o == 2'b11) |=> (bus_oe && ctl_o == 2'b00));
  // R5
  gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && ctl_o == 2'b11) |=> ##1 !bus_oe);
  // R2
  stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && ctl_o == 2'b01) |-> d_o[7:2] == 6'b0);
  // R3
  data_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && ctl_o == 2'b10 && !$past(bus_oe && ctl_o == 2'b10)) |-> d_o == 8'hFF);
  // R6
  tx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> $past(!bus_oe && ctl_i == 2'b01));
  // R9
  end_reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> (bus_oe && ctl_o == 2'b00));
  // R10
  null_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_null |-> !tx_vld);
endmodule

// File: tb/phy_link_seq_tb_top.sv
`timescale 1ns/1ps
module phy_link_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_req = 1'b0;
  logic [7:0] stat_bits = 8'h00;
  logic rx_act = 1'b0;
  logic [2:0] rx_spd = 3'd0;
  logic [7:0] rx_byte = 8'h00;
  logic arb_won = 1'b0;
  logic [2:0] gnt_type = 3'd0;
  logic [2:0] req_spd = 3'd0;
  logic [1:0] ctl_i = 2'b00;
  logic [7:0] d_i = 8'h00;
  logic [1:0] ctl_o;
  logic [7:0] d_o;
  logic bus_oe, tx_vld, tx_null, tx_end;
  logic [7:0] tx_byte;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_link_seq #(.STAT_W(8), .MAX_SPD(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .stat_req(stat_req), .stat_bits(stat_bits),
    .rx_act(rx_act), .rx_spd(rx_spd), .rx_byte(rx_byte), .arb_won(arb_won),
    .gnt_type(gnt_type), .req_spd(req_spd), .ctl_i(ctl_i), .d_i(d_i),
    .ctl_o(ctl_o), .d_o(d_o), .bus_oe(bus_oe), .tx_vld(tx_vld),
    .tx_byte(tx_byte), .tx_null(tx_null), .tx_end(tx_end));

  typedef struct {
    int at; bit oe; bit [1:0] ctl; bit [7:0] d; bit v; bit [7:0] b; bit n; bit e; string r;
  } exp_t;
  exp_t q[$];

  task automatic push(int at, bit oe, bit [1:0] ctl, bit [7:0] d,
                      bit v, bit [7:0] b, bit n, bit e, string r);
    exp_t x;
    x.at = at; x.oe = oe; x.ctl = ctl; x.d = d; x.v = v; x.b = b; x.n = n; x.e = e; x.r = r;
    q.push_back(x);
  endtask

  task automatic pbus(int at, bit [1:0] ctl, bit [7:0] d, string r);
    push(at, 1'b1, ctl, d, 1'b0, 8'h00, 1'b0, 1'b0, r);
  endtask

  always @(negedge clk) begin
    exp_t x;
    bit bad;
    while (q.size() > 0 && q[0].at <= cyc) begin
      x = q.pop_front();
      checks++;
      bad = (x.at != cyc) || (bus_oe !== x.oe) || (tx_vld !== x.v) ||
            (tx_null !== x.n) || (tx_end !== x.e);
      if (x.oe && (ctl_o !== x.ctl || d_o !== x.d)) bad = 1'b1;
      if (x.v && tx_byte !== x.b) bad = 1'b1;
      if (bad) begin
        errors++;
        $display("FAIL %s cycle %0d: got oe=%b ctl=%b d=%h v=%b b=%h n=%b e=%b, expected oe=%b ctl=%b d=%h v=%b b=%h n=%b e=%b (due %0d)",
                 x.r, cyc, bus_oe, ctl_o, d_o, tx_vld, tx_byte, tx_null, tx_end,
                 x.oe, x.ctl, x.d, x.v, x.b, x.n, x.e, x.at);
      end
    end
  end

  task automatic idle_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_pkt(bit [2:0] spd, int n, bit [7:0] b0, bit [7:0] b1, bit [7:0] b2, string r);
    int c;
    bit [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    c = cyc;
    rx_act = 1'b1; rx_spd = spd;
    pbus(c + 1, 2'b10, 8'hFF, r);
    pbus(c + 2, 2'b10, {5'b0, spd}, r);
    for (int i = 0; i < n; i++) pbus(c + 3 + i, 2'b10, bs[i], r);
    pbus(c + n + 3, 2'b00, 8'h00, r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_byte = bs[i];
    end
    @(negedge clk);
    rx_act = 1'b0;
    idle_wait(5);
  endtask

  task automatic finish_run();
    while (q.size() > 0) begin
      errors++; checks++;
      $display("FAIL %s: expected item for cycle %0d never compared", q[0].r, q[0].at);
      void'(q.pop_front());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (bus_oe !== 1'b1 || ctl_o !== 2'b00 || d_o !== 8'h00 || tx_vld !== 1'b0 ||
        tx_null !== 1'b0 || tx_end !== 1'b0) begin
      errors++;
      $display("FAIL R1: got oe=%b ctl=%b d=%h v=%b n=%b e=%b, expected 1 00 00 0 0 0",
               bus_oe, ctl_o, d_o, tx_vld, tx_null, tx_end);
    end
    rst_n = 1'b1;
    idle_wait(2);

    // R2: status word E4h -> pairs 0,1,2,3
    c = cyc;
    stat_req = 1'b1; stat_bits = 8'hE4;
    for (int i = 0; i < 4; i++) pbus(c + 2 + i, 2'b01, 8'(i), "R2");
    pbus(c + 6, 2'b00, 8'h00, "R2");
    @(negedge clk); stat_req = 1'b0;
    idle_wait(8);

    // R3: two receive patterns
    rx_pkt(3'd2, 3, 8'hA5, 8'h3C, 8'hC3, "R3");
    rx_pkt(3'd0, 1, 8'h81, 8'h00, 8'h00, "R3");

    // R4: receive preempts a status transfer already under way
    c = cyc;
    stat_req = 1'b1; stat_bits = 8'hE4;
    pbus(c + 2, 2'b01, 8'h00, "R4");
    pbus(c + 3, 2'b10, 8'hFF, "R4");
    pbus(c + 4, 2'b10, 8'h01, "R4");
    pbus(c + 5, 2'b10, 8'h5A, "R4");
    pbus(c + 6, 2'b00, 8'h00, "R4");
    for (int i = 0; i < 4; i++) pbus(c + 7 + i, 2'b01, 8'(i), "R4");
    pbus(c + 11, 2'b00, 8'h00, "R4");
    @(negedge clk); stat_req = 1'b0;
    @(negedge clk); rx_act = 1'b1; rx_spd = 3'd1;
    @(negedge clk); rx_byte = 8'h5A;
    @(negedge clk); rx_act = 1'b0;
    idle_wait(10);

    // R5 R6 R7 R9: grant, one idle, two transmit bytes, hold, end (speed 3 is the valid limit)
    c = cyc;
    arb_won = 1'b1; gnt_type = 3'd5; req_spd = 3'd3;
    pbus(c + 2, 2'b11, 8'h05, "R5");
    pbus(c + 3, 2'b00, 8'h00, "R5");
    push(c + 4, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R5");
    push(c + 5, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R8");
    push(c + 6, 1'b0, 2'b00, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, "R6");
    push(c + 7, 1'b0, 2'b00, 8'h00, 1'b1, 8'h22, 1'b0, 1'b0, "R6");
    push(c + 8, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    push(c + 9, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R9");
    push(c + 10, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
    @(negedge clk); arb_won = 1'b0;
    idle_wait(3); ctl_i = 2'b00;
    @(negedge clk); ctl_i = 2'b01; d_i = 8'h11;
    @(negedge clk); ctl_i = 2'b01; d_i = 8'h22;
    @(negedge clk); ctl_i = 2'b11; d_i = 8'h77;
    @(negedge clk); ctl_i = 2'b00; d_i = 8'h00;
    idle_wait(6);

    // R11 R8: grant beats pending status; second idle ends ownership; status follows
    c = cyc;
    arb_won = 1'b1; gnt_type = 3'd2; req_spd = 3'd0;
    stat_req = 1'b1; stat_bits = 8'h1B;
    pbus(c + 2, 2'b11, 8'h02, "R11");
    pbus(c + 3, 2'b00, 8'h00, "R5");
    push(c + 4, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R8");
    push(c + 5, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R8");
    push(c + 6, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R8");
    pbus(c + 7, 2'b01, 8'h03, "R11");
    pbus(c + 8, 2'b01, 8'h02, "R11");
    pbus(c + 9, 2'b01, 8'h01, "R11");
    pbus(c + 10, 2'b01, 8'h00, "R11");
    pbus(c + 11, 2'b00, 8'h00, "R11");
    @(negedge clk); arb_won = 1'b0; stat_req = 1'b0;
    idle_wait(14);

    // R10: invalid speed 6 -> null packet, link bytes dropped
    c = cyc;
    arb_won = 1'b1; gnt_type = 3'd5; req_spd = 3'd6;
    pbus(c + 2, 2'b11, 8'h05, "R10");
    pbus(c + 3, 2'b00, 8'h00, "R10");
    push(c + 4, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R10");
    push(c + 5, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R10");
    push(c + 6, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R10");
    push(c + 7, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R10");
    @(negedge clk); arb_won = 1'b0;
    idle_wait(3); ctl_i = 2'b01; d_i = 8'h33;
    @(negedge clk); d_i = 8'h44;
    @(negedge clk); ctl_i = 2'b00; d_i = 8'h00;
    idle_wait(6);

    done = 1'b1;
    finish_run();
  end
endmodule